// File: doc/BRIEF.md
# Asynchronous static RAM cycle sequencer

This block sits between an on-chip agent and an external 128K x 8 asynchronous static RAM. The agent hands over one request at a time, either a byte write or a byte read, on a valid/ready port. The block turns each request into a pin-level cycle on the memory's 17-bit address, its three active-low enables and a bidirectional 8-bit data bus. The bus is split into an output value, a driver enable and an input value, so the pad ring can resolve it.

Every phase of a cycle is a whole number of clock periods. Each count is the ceiling of a memory timing limit divided by the clock period, and both the limits and the period are parameters. All pin outputs come from flops. The chip enable stays high whenever no cycle is in flight, which keeps the memory in standby. After every read, one cycle passes with every enable high before anything else happens. This keeps the block's drivers off the bus until the memory has let go of it.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The agent must hold `req_valid` and the request fields steady until that edge. Read results come back on `rsp_valid` with no ready: the agent must accept them in the cycle they appear.

Top module: `sram_async_ctrl`

## Requirements
- R1: `req_ready` is 1 exactly in idle cycles. A request with `req_valid` high is taken at the first edge where `req_ready` is high, and `req_ready` is 0 in the cycle after a request is taken.
- R2: A write taken at the edge that ends cycle c runs through four phases. Cycle c+1 is the address setup: CE low, WE high, OE high, address already valid. Cycles c+2 and c+3 are the write pulse, with WE low. Cycle c+4 is the hold, with WE high. `req_ready` returns in cycle c+5.
- R3: WE stays low for at least WP_CYC cycles (2 at default timing). The data drivers are on, with the request byte, in every WE-low cycle and in the hold cycle that follows.
- R4: The address pins do not change from the setup cycle through the hold cycle of a write, nor during the OE-low cycles of a read.
- R5: A read taken at the edge that ends cycle c drives CE low and OE low with WE high for RD_CYC cycles (2 at default timing), in c+1 and c+2. The bus is sampled at the end of the last of these cycles. `rsp_valid` is high for exactly one cycle, c+3, with that byte on `rsp_rdata`.
- R6: After the last OE-low cycle of a read there is one cycle with all enables high. The data drivers are never on in a cycle where OE is low, nor in the cycle right after one. `req_ready` returns in cycle c+4 after a read.
- R7: In an idle cycle CE, WE and OE are all high and the data drivers are off.
- R8: During and right after reset, all three enables are high, the drivers are off, `req_ready` is 1 and `rsp_valid` is 0.
- R9: A read returns the last byte written to that address, across the whole 17-bit range, including addresses 0 and 0x1FFFF.
- R10: OE is high throughout every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 17 | Memory address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |
| sram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The hardest case to reach from the ports is a read that samples the bus one cycle too early. A memory that answers at once would hide it. The bench's memory model therefore returns the inverted byte until the address and OE have been steady for RD_CYC cycles, so an early capture shows up as a miscompare. Requests come from a small pool of addresses that includes both ends of the range. The mix is random, with idle gaps and held requests. This produces write-after-read, read-after-write to the same byte and back-to-back reads, and the model checks pulse width, setup and contention on every one of them.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WSETUP = 3'd1,
    PH_WPULSE = 3'd2,
    PH_WHOLD  = 3'd3,
    PH_RACC   = 3'd4,
    PH_TURN   = 3'd5
  } phase_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= load;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            nxt_phase,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_ld,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
    end else begin
      if (addr_ld) sram_addr   <= addr_in;
      if (data_ld) sram_dq_out <= data_in;
      sram_ce_n  <= (nxt_phase == PH_IDLE) || (nxt_phase == PH_TURN);
      sram_we_n  <= (nxt_phase != PH_WPULSE);
      sram_oe_n  <= (nxt_phase != PH_RACC);
      sram_dq_oe <= (nxt_phase == PH_WPULSE) || (nxt_phase == PH_WHOLD);
    end
  end

  // Width of the current write pulse, for the pulse-width check.
  logic [7:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              we_low_cnt <= '0;
    else if (sram_we_n)                      we_low_cnt <= '0;
    else if (we_low_cnt != 8'hFF)            we_low_cnt <= we_low_cnt + 1'b1;
  end

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |=> !sram_dq_oe);
  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (int'(we_low_cnt) >= WP_CYC));
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> $stable(sram_addr));
  assert_oe_high_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);
  assert_drive_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 5000,
  parameter int T_WP_PS = 7000,
  parameter int T_DW_PS = 5000,
  parameter int T_AW_PS = 8000,
  parameter int T_AA_PS = 10000,
  parameter int T_OE_PS = 5000,
  parameter int T_HZ_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int SETUP_CYC = 1;
  localparam int HOLD_CYC  = 1;
  localparam int WP_CYC    = max2(1, ceil_div(max2(max2(T_WP_PS, T_DW_PS), T_AW_PS), CLK_PS));
  localparam int RD_CYC    = max2(1, ceil_div(max2(T_AA_PS, T_OE_PS), CLK_PS));
  localparam int TURN_CYC  = max2(1, ceil_div(T_HZ_PS, CLK_PS));
  localparam int MAXC      = max2(max2(WP_CYC, RD_CYC), TURN_CYC);
  localparam int CW        = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_WP    = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_RD    = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] LD_TURN  = CW'(TURN_CYC - 1);

  phase_e        phase_q, phase_d;
  logic          t_start, t_done;
  logic [CW-1:0] t_load;
  logic          accept;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_d = phase_q;
    t_start = 1'b0;
    t_load  = '0;
    unique case (phase_q)
      PH_IDLE: if (req_valid) begin
        t_start = 1'b1;
        if (req_we) begin phase_d = PH_WSETUP; t_load = LD_SETUP; end
        else        begin phase_d = PH_RACC;   t_load = LD_RD;    end
      end
      PH_WSETUP: if (t_done) begin phase_d = PH_WPULSE; t_start = 1'b1; t_load = LD_WP; end
      PH_WPULSE: if (t_done) begin phase_d = PH_WHOLD;  t_start = 1'b1; t_load = LD_HOLD; end
      PH_WHOLD:  if (t_done) phase_d = PH_IDLE;
      PH_RACC:   if (t_done) begin phase_d = PH_TURN;   t_start = 1'b1; t_load = LD_TURN; end
      PH_TURN:   if (t_done) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (t_start),
    .load  (t_load),
    .done  (t_done)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_CYC(WP_CYC)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .nxt_phase   (phase_d),
    .addr_ld     (accept),
    .addr_in     (req_addr),
    .data_ld     (accept && req_we),
    .data_in     (req_wdata),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

  // Capture in the last OE-low cycle, present as a one-cycle pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (phase_q == PH_RACC) && t_done;
      if ((phase_q == PH_RACC) && t_done) rsp_rdata <= sram_dq_in;
    end
  end

  assert_taken_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!sram_oe_n) && sram_oe_n));
  assert_idle_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));
  assert_read_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));
endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int CLK_PS = 5000;
  localparam int WP_CYC = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int RD_CYC = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int NOPS   = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, sram_dq_in = '0;
  logic req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rsp_rdata, sram_dq_out;
  logic [16:0] sram_addr;

  always #2.5 clk = ~clk;

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int vectors = 0, fails = 0;
  bit finished = 0;
  byte unsigned model_mem[int];
  byte unsigned ref_mem[int];

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a ^ (a >> 8) ^ (a >> 13) ^ 8'h3C);
  endfunction
  function automatic logic [7:0] model_rd(input int a);
    return model_mem.exists(a) ? 8'(model_mem[a]) : init_byte(a);
  endfunction
  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? 8'(ref_mem[a]) : init_byte(a);
  endfunction
  function automatic logic [16:0] pick_addr(input int n);
    case (n % 8)
      0: return 17'h00000;  1: return 17'h1FFFF;
      2: return 17'h00001;  3: return 17'h10000;
      4: return 17'h0AAAA;  5: return 17'h15555;
      6: return 17'h000FF;  default: return 17'h1FF00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int busy_until = -1, rsp_at = -100, op = 0, c = 0, wlen = 0, rd_run = 0;
    bit pend = 0, p_ce = 1, p_we = 1, p_oe = 1;
    logic [16:0] p_addr = '0;
    logic [7:0]  exp_rd = '0;
    logic [31:0] seed = 32'h1234_5678;

    repeat (3) @(negedge clk);
    // R8: state while reset is held
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R8 pins in reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    chk(req_ready && !rsp_valid, "R8 handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;

    while (op < NOPS || c <= busy_until + 2) begin
      @(negedge clk);
      // Outputs against the reference schedule
      chk(req_ready == (c > busy_until), "R1 req_ready", req_ready, c > busy_until);
      chk(rsp_valid == (c == rsp_at), "R5 rsp_valid", rsp_valid, c == rsp_at);
      if (c == rsp_at) chk(rsp_rdata == exp_rd, "R9 rsp_rdata", rsp_rdata, exp_rd);
      if (c == 0)
        chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R8 pins after reset",
            {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);

      // Memory model: contention, standby, write and read rules
      chk(!(sram_dq_oe && (!sram_oe_n || !p_oe)), "R6 bus turnaround",
          {sram_dq_oe, sram_oe_n, p_oe}, 3'b011);
      if (c > busy_until)
        chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R7 idle pins",
            {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
      if (!sram_we_n) begin
        chk(!sram_ce_n && sram_oe_n, "R10 enables in pulse", {sram_ce_n, sram_oe_n}, 2'b01);
        chk(sram_dq_oe, "R3 drive in pulse", sram_dq_oe, 1);
        if (p_we) chk(!p_ce && p_addr == sram_addr, "R2 address setup", p_addr, sram_addr);
        else      chk(p_addr == sram_addr, "R4 address in pulse", sram_addr, p_addr);
        wlen++;
      end else if (!p_we) begin
        chk(wlen >= WP_CYC, "R3 pulse width", wlen, WP_CYC);
        chk(sram_dq_oe && !sram_ce_n && sram_addr == p_addr, "R4 hold after pulse",
            sram_addr, p_addr);
        model_mem[int'(sram_addr)] = sram_dq_out;
        wlen = 0;
      end
      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
        if (!p_oe && sram_addr == p_addr) rd_run++;
        else rd_run = 1;
        sram_dq_in = (rd_run >= RD_CYC) ? model_rd(int'(sram_addr)) : ~model_rd(int'(sram_addr));
      end else rd_run = 0;
      p_ce = sram_ce_n; p_we = sram_we_n; p_oe = sram_oe_n; p_addr = sram_addr;

      // Stimulus: hold a request until taken (R1 back-pressure)
      if (!pend && op < NOPS) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        if (op < 4 || seed[20:19] != 2'b00) begin
          pend = 1;
          case (op)
            0: begin req_we = 1; req_addr = 17'h1FFFF; req_wdata = 8'hA5; end
            1: begin req_we = 0; req_addr = 17'h1FFFF; end
            2: begin req_we = 0; req_addr = 17'h00000; end
            3: begin req_we = 1; req_addr = 17'h00000; req_wdata = 8'h5A; end
            default: begin
              req_we = seed[27]; req_addr = pick_addr(int'(seed[30:28]) + int'(seed[5:3]));
              req_wdata = seed[15:8];
            end
          endcase
        end
      end
      req_valid = pend;
      if (pend && c > busy_until) begin
        if (req_we) begin
          ref_mem[int'(req_addr)] = req_wdata;
          busy_until = c + 4;
        end else begin
          exp_rd = ref_rd(int'(req_addr));
          rsp_at = c + 3;
          busy_until = c + 3;
        end
        pend = 0;
        op++;
      end
      c++;
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule